// File: doc/BRIEF.md
# I2C Multi-Address Slave Matcher

This block decides whether the first byte that follows a bus START (or repeated START) is addressed to this device. It holds four programmable address slots. Each slot carries a 7-bit address, a general-call enable and a 7-bit don't-care mask. The receive front end pulses `start_seen` when it detects a START condition. It then presents the assembled first byte, with the address in bits 7:1 and the R/W bit in bit 0, on `rx_byte` with a one-cycle `byte_vld` strobe.

On a hit, the block emits a one-cycle `match_pulse` and reports which slot hit. It raises `gen_call` when the hit was a general call. It latches the full received byte on `rx_addr`, so that software can tell which of several enabled addresses was used. It also sets a sticky interrupt request. Software programs the slots through a small write-only register port. Offsets 0 to 3 are the address registers: address in bits 7:1, general-call enable in bit 0. Offsets 4 to 7 are the mask registers of slots 0 to 3, with active bits 7:1. Offset 8 is the control register, where bit 0 is write-one-to-clear for the interrupt. START detection, bit sampling, ACK generation and the data phase sit outside this block.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While `rst_n` is low and right after reset, `match_pulse`, `match_slot`, `gen_call`, `rx_addr` and `irq` are 0, and all address and mask registers are 0.
- R2: A first byte whose bits 7:1 equal bits 7:1 of a slot's address register is a hit for that slot whatever its bit 0 (R/W). `match_pulse` is high for exactly the one cycle after the `byte_vld` cycle, and `match_slot` then shows the slot index.
- R3: A mask register bit k (k in 7:1) set to 1 removes address bit k from that slot's comparison. Unmasked bits must still agree.
- R4: When several slots hit, the lowest-indexed one is reported.
- R5: A slot whose address bits 7:1 and mask bits 7:1 are all zero is disabled and never hits.
- R6: A first byte of exactly 0x00 is a general call when at least one slot has bit 0 of its address register set. The block then reports `gen_call`=1, `match_pulse`=1, and `match_slot` = the lowest slot with general-call enabled. This outcome overrides any masked address hit. Byte 0x01 is never a general call.
- R7: `rx_addr` takes the whole received byte on every hit and holds its value otherwise.
- R8: `irq` rises together with `match_pulse` and stays high until a write to offset 8 with bit 0 = 1. A write with bit 0 = 0 leaves it set. A hit in the same cycle as a clear leaves it set.
- R9: Only the first `byte_vld` after a `start_seen` pulse is evaluated. A later byte, or a byte with no preceding START, never produces a hit.
- R10: A first byte that hits nothing gives no `match_pulse`, and leaves `irq`, `match_slot`, `gen_call` and `rx_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset (0-3 address, 4-7 mask, 8 control) |
| cfg_wdata | input | 8 | Register write data |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte, address in 7:1, R/W in bit 0 |
| match_pulse | output | 1 | One-cycle hit indication |
| match_slot | output | 2 | Index of the reported slot |
| gen_call | output | 1 | Last hit was a general call |
| rx_addr | output | 8 | Received byte of the last hit |
| irq | output | 1 | Sticky interrupt request |

## Verification
A fixed configuration is used: two slots overlap on the same address, one slot masks its two low address bits, one slot enables general call, and one slot is left all-zero. Bytes are sent against this configuration so that each separates a different rule. Equal addresses with both R/W values show that bit 0 is ignored. Bytes inside and just outside the masked range separate masked from unmasked bits. The overlapping address shows which priority is applied. Bytes 0x00 and 0x01 separate the general call from an address-zero read and from a disabled slot. Directed sequences then cover a general call that competes with a fully masked slot, a clear of the interrupt that lands in the same cycle as a hit, bytes sent without a START, and misses that must leave the captured state untouched.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;
   // bit of the control register that clears the interrupt when written as 1
   localparam int unsigned CTRL_IRQ_CLR_BIT = 0;
   // bit of an address register that enables general-call recognition
   localparam int unsigned GC_ENABLE_BIT = 0;
endpackage

// File: rtl/i2c_match_regs.sv
module i2c_match_regs
   import i2c_match_pkg::*;
#(
   parameter int unsigned N_SLOTS = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned RAW     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [RAW-1:0]                waddr,
   input  logic [DW-1:0]                 wdata,
   output logic [N_SLOTS-1:0][DW-1:0]    addr_q,
   output logic [N_SLOTS-1:0][DW-1:0]    mask_q,
   output logic                          irq_clr
);
   localparam int unsigned CTRL_OFS = 2 * N_SLOTS;

   if (RAW < $clog2(2 * N_SLOTS + 1)) begin : g_bad_raw
      $error("register offset width too small for slot count");
   end

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q[i] <= '0;
            mask_q[i] <= '0;
         end else if (we) begin
            if (waddr == RAW'(i))           addr_q[i] <= wdata;
            if (waddr == RAW'(N_SLOTS + i)) mask_q[i] <= wdata;
         end
      end
   end

   assign irq_clr = we && (waddr == RAW'(CTRL_OFS)) && wdata[CTRL_IRQ_CLR_BIT];
endmodule

// File: rtl/i2c_slot_cmp.sv
module i2c_slot_cmp
   import i2c_match_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic [DW-1:0] addr_r,
   input  logic [DW-1:0] mask_r,
   input  logic [DW-1:0] rx_byte,
   output logic          hit,
   output logic          gc_en
);
   logic [DW-2:0] diff;
   logic          enabled;

   assign diff    = (rx_byte[DW-1:1] ^ addr_r[DW-1:1]) & ~mask_r[DW-1:1];
   assign enabled = (addr_r[DW-1:1] != '0) || (mask_r[DW-1:1] != '0);
   assign hit     = enabled && (diff == '0);
   assign gc_en   = addr_r[GC_ENABLE_BIT];
endmodule

// File: rtl/i2c_prio_enc.sv
module i2c_prio_enc #(
   parameter int unsigned N  = 4,
   parameter int unsigned SW = 2
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [SW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = SW'(i);
      end
      found = |req;
   end

   always_comb begin
      if (found) begin
         AST_PRIO_VALID: assert (req[idx]); // R4
      end
   end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher #(
   parameter int unsigned N_SLOTS      = 4,
   parameter int unsigned AW           = 7,
   parameter bit          GC_OVERRIDES = 1'b1,
   localparam int unsigned DW  = AW + 1,
   localparam int unsigned SW  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
   localparam int unsigned RAW = $clog2(2 * N_SLOTS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [RAW-1:0] cfg_addr,
   input  logic [DW-1:0]  cfg_wdata,
   input  logic           start_seen,
   input  logic           byte_vld,
   input  logic [DW-1:0]  rx_byte,
   output logic           match_pulse,
   output logic [SW-1:0]  match_slot,
   output logic           gen_call,
   output logic [DW-1:0]  rx_addr,
   output logic           irq
);
   if (N_SLOTS < 1) begin : g_bad_slots
      $error("at least one address slot is required");
   end
   if (AW < 2) begin : g_bad_aw
      $error("address width must be at least 2");
   end

   logic [N_SLOTS-1:0][DW-1:0] addr_q, mask_q;
   logic                       irq_clr;
   logic [N_SLOTS-1:0]         slot_hit, slot_gc;
   logic                       addr_found, gc_found;
   logic [SW-1:0]              addr_idx, gc_idx;
   logic                       armed, eval, gc_hit, take_gc, take_slot, hit_any;
   logic [SW-1:0]              slot_sel;

   i2c_match_regs #(.N_SLOTS(N_SLOTS), .DW(DW), .RAW(RAW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
      .addr_q(addr_q), .mask_q(mask_q), .irq_clr(irq_clr)
   );

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
      i2c_slot_cmp #(.DW(DW)) u_cmp (
         .addr_r(addr_q[i]), .mask_r(mask_q[i]), .rx_byte(rx_byte),
         .hit(slot_hit[i]), .gc_en(slot_gc[i])
      );
   end

   i2c_prio_enc #(.N(N_SLOTS), .SW(SW)) u_addr_pe (
      .req(slot_hit), .found(addr_found), .idx(addr_idx)
   );
   i2c_prio_enc #(.N(N_SLOTS), .SW(SW)) u_gc_pe (
      .req(slot_gc), .found(gc_found), .idx(gc_idx)
   );

   assign gc_hit = (rx_byte == '0) && gc_found;

   if (GC_OVERRIDES) begin : g_gc_first
      assign take_gc   = gc_hit;
      assign take_slot = addr_found && !gc_hit;
   end else begin : g_addr_first
      assign take_slot = addr_found;
      assign take_gc   = gc_hit && !addr_found;
   end

   assign hit_any  = take_gc || take_slot;
   assign slot_sel = take_gc ? gc_idx : addr_idx;
   assign eval     = byte_vld && armed;

   // first-byte window: opened by START, closed by the next byte
   always_ff @(posedge clk) begin
      if (!rst_n)          armed <= 1'b0;
      else if (start_seen) armed <= 1'b1;
      else if (byte_vld)   armed <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
         match_slot  <= '0;
         gen_call    <= 1'b0;
         rx_addr     <= '0;
         irq         <= 1'b0;
      end else begin
         match_pulse <= eval && hit_any;
         if (eval && hit_any) begin
            match_slot <= slot_sel;
            gen_call   <= take_gc;
            rx_addr    <= rx_byte;
            irq        <= 1'b1;
         end else if (irq_clr) begin
            irq        <= 1'b0;
         end
      end
   end

   AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(byte_vld && armed)); // R9
   AST_IRQ_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> irq); // R8
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq); // R8
   AST_RXADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !match_pulse |-> $stable(rx_addr)); // R7
   AST_GC_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && gen_call) |-> (rx_addr == '0)); // R6
   AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> !match_pulse); // R2
endmodule

// File: tb/sim_i2c_addr_matcher.sv
`timescale 1ns/1ps
module sim_i2c_addr_matcher;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we;
   logic [3:0] cfg_addr;
   logic [7:0] cfg_wdata;
   logic       start_seen, byte_vld;
   logic [7:0] rx_byte;
   logic       match_pulse, gen_call, irq;
   logic [1:0] match_slot;
   logic [7:0] rx_addr;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   i2c_addr_matcher u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .start_seen(start_seen), .byte_vld(byte_vld),
      .rx_byte(rx_byte), .match_pulse(match_pulse), .match_slot(match_slot),
      .gen_call(gen_call), .rx_addr(rx_addr), .irq(irq)
   );

   // {byte, hit, gc, slot}
   localparam logic [11:0] VEC [11] = '{
      {8'hA0, 1'b1, 1'b0, 2'd0},   // R2 R4 overlap of slots 0 and 1
      {8'hA1, 1'b1, 1'b0, 2'd0},   // R2 R/W bit ignored
      {8'hA4, 1'b1, 1'b0, 2'd1},   // R3 masked bit 2
      {8'hA6, 1'b1, 1'b0, 2'd1},   // R3 masked bits 2:1
      {8'hA2, 1'b1, 1'b0, 2'd1},   // R3 masked bit 1
      {8'hA8, 1'b0, 1'b0, 2'd0},   // R3 bit 3 not masked
      {8'h30, 1'b1, 1'b0, 2'd2},   // R2 slot 2
      {8'h31, 1'b1, 1'b0, 2'd2},   // R2 slot 2 read
      {8'h00, 1'b1, 1'b1, 2'd2},   // R6 general call
      {8'h01, 1'b0, 1'b0, 2'd0},   // R5 R6 not a general call, slot 3 off
      {8'h20, 1'b0, 1'b0, 2'd0}    // R10 plain miss
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // START then first byte; optional clear write in the byte cycle
   task automatic send_first(input logic [7:0] b, input logic clr);
      @(negedge clk);
      start_seen = 1'b1;
      @(negedge clk);
      start_seen = 1'b0; byte_vld = 1'b1; rx_byte = b;
      if (clr) begin cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 8'h01; end
      @(negedge clk);
      byte_vld = 1'b0; cfg_we = 1'b0;
   endtask

   task automatic send_plain(input logic [7:0] b);
      @(negedge clk);
      byte_vld = 1'b1; rx_byte = b;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      start_seen = 1'b0; byte_vld = 1'b0; rx_byte = '0;
      repeat (4) @(negedge clk);
      check("R1 pulse", match_pulse, 0);
      check("R1 irq", irq, 0);
      check("R1 rx_addr", rx_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 slot", match_slot, 0);
      check("R1 gen_call", gen_call, 0);

      // reset registers: every slot disabled, no general call enabled
      send_first(8'h00, 1'b0);
      check("R1 R5 zero byte", match_pulse, 0);
      send_first(8'h01, 1'b0);
      check("R5 zero slots", match_pulse, 0);
      check("R5 irq", irq, 0);

      wr(4'd0, 8'hA0); wr(4'd4, 8'h00);
      wr(4'd1, 8'hA0); wr(4'd5, 8'h06);
      wr(4'd2, 8'h31); wr(4'd6, 8'h00);
      wr(4'd3, 8'h00); wr(4'd7, 8'h00);

      for (int i = 0; i < 11; i++) begin
         wr(4'd8, 8'h01);
         send_first(VEC[i][11:4], 1'b0);
         check($sformatf("R2 vec%0d pulse", i), match_pulse, VEC[i][3]);
         if (VEC[i][3]) begin
            check($sformatf("R4 vec%0d slot", i), match_slot, VEC[i][1:0]);
            check($sformatf("R6 vec%0d gc", i), gen_call, VEC[i][2]);
            check($sformatf("R7 vec%0d rx_addr", i), rx_addr, VEC[i][11:4]);
            check($sformatf("R8 vec%0d irq", i), irq, 1);
         end else begin
            check($sformatf("R10 vec%0d irq", i), irq, 0);
         end
      end

      // R7 R10: a miss keeps captured byte, slot and irq
      send_first(8'hA1, 1'b0);
      check("R7 capture", rx_addr, 8'hA1);
      send_first(8'h20, 1'b0);
      check("R10 pulse", match_pulse, 0);
      check("R7 hold rx_addr", rx_addr, 8'hA1);
      check("R10 hold slot", match_slot, 0);
      check("R10 hold irq", irq, 1);

      // R8 clear behaviour
      wr(4'd8, 8'h00);
      check("R8 write zero keeps irq", irq, 1);
      send_first(8'h30, 1'b0);
      check("R8 stays set on new hit", irq, 1);
      wr(4'd8, 8'h01);
      check("R8 clear", irq, 0);
      send_first(8'h30, 1'b1);
      check("R8 hit beats clear", irq, 1);
      check("R8 hit beats clear pulse", match_pulse, 1);

      // R9 later bytes and bytes with no START
      wr(4'd8, 8'h01);
      send_plain(8'hA0);
      check("R9 second byte pulse", match_pulse, 0);
      check("R9 second byte irq", irq, 0);
      send_plain(8'h30);
      check("R9 no start", match_pulse, 0);
      check("R9 rx_addr held", rx_addr, 8'h30);

      // R6 general call beats a fully masked slot 0
      wr(4'd4, 8'hFE);
      send_first(8'h00, 1'b0);
      check("R6 precedence gc", gen_call, 1);
      check("R6 precedence slot", match_slot, 2);
      send_first(8'h40, 1'b0);
      check("R3 full mask slot", match_slot, 0);
      check("R6 gc cleared on address hit", gen_call, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule